// File: doc/BRIEF.md
# Remote DMA Data Port

This block lets a host walk through a local packet memory one access at a time through a single data port. Software first loads a transfer pointer and a remaining byte count. Each load writes one byte, either the low half or the high half of the register. The host then issues read or write strobes on the port. Each accepted strobe touches memory at the pointer, moves the pointer on by the width of the access, and folds it back to the start of the receive ring when it lands on the ring's stop page. It also decrements the count. When the count is used up, the block raises a sticky completion flag. The same flag is raised when a remote transfer command is issued while the count is already zero.

The access width is one byte by default. A level input selects two-byte accesses, and a per-strobe input requests a four-byte access. The memory side has four byte lanes, each with its own address, so a multi-byte access at any even address is one memory cycle. Memory is reachable in two places only: a small address-PROM window at the bottom of the address space, and a packet memory window set by parameters. Accesses that leave both windows read as all ones and do not write.

A two-state machine sequences the port. In `ST_IDLE` the block accepts a strobe. The transition *read accept* (`ST_IDLE` to `ST_RDATA`) is taken on a read strobe. `ST_RDATA` presents the data from the synchronous memory for one cycle. The transition *data return* (`ST_RDATA` to `ST_IDLE`) is unconditional. Writes complete inside `ST_IDLE` without a state change.

Top module: `rdma_data_port`

## Requirements
- R1: After reset the pointer is 0, the remaining count is 0, the completion flag is 0 and `host_rvalid` is 0.
- R2: The pointer and the count are each loaded one byte at a time. `ld_addr_lo`/`ld_cnt_lo` write bits 7:0 from `reg_wdata`. `ld_addr_hi`/`ld_cnt_hi` write bits 15:8.
- R3: An access is 4 bytes when `host_long` is 1. Otherwise it is 2 bytes when `cfg_word` is 1, and 1 byte in all other cases. After each accepted access the pointer grows by that width.
- R4: If the grown pointer equals `ring_stop_pg`×256, the pointer becomes `ring_start_pg`×256 instead.
- R5: If the remaining count is less than or equal to the access width, the count becomes 0 and the completion flag is set. Otherwise the count drops by the width.
- R6: A write strobe while the count is 0 is ignored. No lane write enable rises, and the pointer, the count and the flag stay unchanged.
- R7: For 2- and 4-byte accesses, memory is addressed at the pointer with bit 0 cleared. Lane k (address base+k) carries data bits 8k+7:8k, so the lowest address holds the least significant byte.
- R8: An access is in range only if all its bytes lie below `PROM_BYTES`, or all lie in [`PKT_BASE`, `PKT_END`). An out-of-range read returns all ones in the access width, with upper bits 0. An out-of-range write raises no write enable but still advances the pointer and the count.
- R9: Read data is on `host_rdata` with `host_rvalid` high in the cycle after the read strobe. Data narrower than 32 bits is zero-extended.
- R10: A `cmd_remote` pulse while the count is 0 sets the completion flag in the next cycle. With a nonzero count it has no effect.
- R11: An `irq_clr` pulse clears the completion flag when no completion occurs in the same cycle.
- R12: A read strobe while the count is 0 is still performed. It advances the pointer and sets the completion flag.
- R13: Strobes seen in `ST_RDATA` are ignored, so a read strobe held for two cycles makes exactly one access. A read strobe takes precedence over a simultaneous write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Data-port read strobe |
| host_wr | input | 1 | Data-port write strobe |
| host_long | input | 1 | Request a 4-byte access for this strobe |
| host_wdata | input | 32 | Write data, little-endian |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data present this cycle |
| cfg_word | input | 1 | Selects 2-byte accesses |
| ring_start_pg | input | 8 | Ring start page |
| ring_stop_pg | input | 8 | Ring stop page (one past the end) |
| reg_wdata | input | 8 | Byte for register loads |
| ld_addr_lo | input | 1 | Load pointer bits 7:0 |
| ld_addr_hi | input | 1 | Load pointer bits 15:8 |
| ld_cnt_lo | input | 1 | Load count bits 7:0 |
| ld_cnt_hi | input | 1 | Load count bits 15:8 |
| cmd_remote | input | 1 | A remote read/write command was issued |
| irq_clr | input | 1 | Clear the completion flag |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 4 | Per-lane write enables |
| mem_addr | output | 64 | Four 16-bit lane addresses, lane 0 lowest |
| mem_wdata | output | 32 | Lane write data |
| mem_rdata | input | 32 | Lane read data, one cycle after mem_rd |
| cur_addr | output | 16 | Current pointer |
| rem_cnt | output | 16 | Remaining byte count |
| rdc_flag | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with a packet window of 0x0400 to 0x0600 and a ring that spans pages 0x04 to 0x06. With this small window a few accesses reach the ring fold at 0x0600. They also reach the gap between the PROM window and the packet window, which reads all ones, and accesses that straddle the upper PROM limit or the window end. The small window keeps every address inside a 2 KiB behavioural memory. The default parameters place the window much higher, where none of these cases would be reachable quickly.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int LANES = 4;
    localparam int NB_W  = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } port_state_e;

    function automatic logic [NB_W-1:0] width_of(input logic is_long, input logic is_word);
        if (is_long)
            return NB_W'(4);
        else if (is_word)
            return NB_W'(2);
        else
            return NB_W'(1);
    endfunction

endpackage

// File: rtl/rdma_window_chk.sv
module rdma_window_chk #(
    parameter int ADDR_W     = 16,
    parameter int PROM_BYTES = 32,
    parameter int PKT_BASE   = 'h4000,
    parameter int PKT_END    = 'h8000
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [rdma_pkg::NB_W-1:0]  nbytes,
    output logic                       in_range
);
    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] PROM_LIM = SUM_W'(PROM_BYTES);
    localparam logic [SUM_W-1:0] BASE_LIM = SUM_W'(PKT_BASE);
    localparam logic [SUM_W-1:0] END_LIM  = SUM_W'(PKT_END);

    logic [SUM_W-1:0] first_b;
    logic [SUM_W-1:0] past_end;

    always_comb begin
        first_b  = {1'b0, addr};
        past_end = first_b + SUM_W'(nbytes);
        in_range = (past_end <= PROM_LIM) ||
                   ((first_b >= BASE_LIM) && (past_end <= END_LIM));
    end
endmodule

// File: rtl/rdma_lane_map.sv
module rdma_lane_map #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]                    base,
    input  logic [rdma_pkg::NB_W-1:0]            nbytes,
    input  logic                                 in_range,
    input  logic                                 wr_go,
    input  logic [8*rdma_pkg::LANES-1:0]         host_wdata,
    input  logic [rdma_pkg::NB_W-1:0]            rd_nbytes,
    input  logic                                 rd_in_range,
    input  logic [8*rdma_pkg::LANES-1:0]         mem_rdata,
    output logic [rdma_pkg::LANES*ADDR_W-1:0]    mem_addr,
    output logic [rdma_pkg::LANES-1:0]           mem_we,
    output logic [8*rdma_pkg::LANES-1:0]         mem_wdata,
    output logic [8*rdma_pkg::LANES-1:0]         host_rdata
);
    localparam int LANES = rdma_pkg::LANES;
    localparam int NB_W  = rdma_pkg::NB_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_on_wr;
        logic lane_on_rd;
        assign lane_on_wr = NB_W'(k) < nbytes;
        assign lane_on_rd = NB_W'(k) < rd_nbytes;
        assign mem_addr[k*ADDR_W +: ADDR_W] = base + ADDR_W'(k);
        assign mem_we[k]                    = wr_go && in_range && lane_on_wr;
        assign mem_wdata[8*k +: 8]          = host_wdata[8*k +: 8];
        assign host_rdata[8*k +: 8]         = !lane_on_rd  ? 8'h00 :
                                              rd_in_range ? mem_rdata[8*k +: 8] : 8'hFF;
    end
endmodule

// File: rtl/rdma_ptr_ctl.sv
module rdma_ptr_ctl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic [rdma_pkg::NB_W-1:0]   nbytes,
    input  logic [7:0]                  reg_wdata,
    input  logic                        ld_addr_lo,
    input  logic                        ld_addr_hi,
    input  logic                        ld_cnt_lo,
    input  logic                        ld_cnt_hi,
    input  logic [ADDR_W-9:0]           ring_start_pg,
    input  logic [ADDR_W-9:0]           ring_stop_pg,
    input  logic                        cmd_remote,
    input  logic                        irq_clr,
    output logic [ADDR_W-1:0]           cur_addr,
    output logic [CNT_W-1:0]            rem_cnt,
    output logic                        rdc_flag
);
    localparam int AHI_W = ADDR_W - 8;
    localparam int CHI_W = CNT_W - 8;

    logic [ADDR_W-1:0] start_addr, stop_addr, grown, addr_d;
    logic [CNT_W-1:0]  size_c, cnt_d;
    logic              done, flag_set, flag_d;

    always_comb begin
        start_addr = {ring_start_pg, 8'h00};
        stop_addr  = {ring_stop_pg, 8'h00};
        grown      = cur_addr + ADDR_W'(nbytes);
        size_c     = CNT_W'(nbytes);
        done       = step && (rem_cnt <= size_c);

        addr_d = cur_addr;
        if (step)
            addr_d = (grown == stop_addr) ? start_addr : grown;
        if (ld_addr_lo) addr_d[7:0]        = reg_wdata;
        if (ld_addr_hi) addr_d[ADDR_W-1:8] = AHI_W'(reg_wdata);

        cnt_d = rem_cnt;
        if (step)
            cnt_d = done ? '0 : (rem_cnt - size_c);
        if (ld_cnt_lo) cnt_d[7:0]       = reg_wdata;
        if (ld_cnt_hi) cnt_d[CNT_W-1:8] = CHI_W'(reg_wdata);

        flag_set = done || (cmd_remote && (rem_cnt == '0));
        flag_d   = flag_set ? 1'b1 : (irq_clr ? 1'b0 : rdc_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_cnt  <= '0;
            rdc_flag <= 1'b0;
        end else begin
            cur_addr <= addr_d;
            rem_cnt  <= cnt_d;
            rdc_flag <= flag_d;
        end
    end

    // R4: landing on the stop page folds back to the ring start
    a_r4_ring_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_addr_lo && !ld_addr_hi &&
         (ADDR_W'(cur_addr + ADDR_W'(nbytes)) == {ring_stop_pg, 8'h00}))
        |=> (cur_addr == $past(start_addr)));

    // R5: exhausting the count leaves zero and a raised flag
    a_r5_count_done: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (rem_cnt <= CNT_W'(nbytes)) && !ld_cnt_lo && !ld_cnt_hi)
        |=> (rem_cnt == '0) && rdc_flag);

    // R10: remote command with zero count flags completion
    a_r10_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_remote && (rem_cnt == '0)) |=> rdc_flag);
endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port
    import rdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PROM_BYTES = 32,
    parameter int PKT_BASE   = 'h4000,
    parameter int PKT_END    = 'h8000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_rd,
    input  logic                               host_wr,
    input  logic                               host_long,
    input  logic [8*rdma_pkg::LANES-1:0]       host_wdata,
    output logic [8*rdma_pkg::LANES-1:0]       host_rdata,
    output logic                               host_rvalid,
    input  logic                               cfg_word,
    input  logic [ADDR_W-9:0]                  ring_start_pg,
    input  logic [ADDR_W-9:0]                  ring_stop_pg,
    input  logic [7:0]                         reg_wdata,
    input  logic                               ld_addr_lo,
    input  logic                               ld_addr_hi,
    input  logic                               ld_cnt_lo,
    input  logic                               ld_cnt_hi,
    input  logic                               cmd_remote,
    input  logic                               irq_clr,
    output logic                               mem_rd,
    output logic [rdma_pkg::LANES-1:0]         mem_we,
    output logic [rdma_pkg::LANES*ADDR_W-1:0]  mem_addr,
    output logic [8*rdma_pkg::LANES-1:0]       mem_wdata,
    input  logic [8*rdma_pkg::LANES-1:0]       mem_rdata,
    output logic [ADDR_W-1:0]                  cur_addr,
    output logic [CNT_W-1:0]                   rem_cnt,
    output logic                               rdc_flag
);
    port_state_e        state, state_d;
    logic [NB_W-1:0]    nbytes, rd_nbytes;
    logic [ADDR_W-1:0]  base;
    logic               cnt_zero, acc_rd, acc_wr, step;
    logic               in_range, rd_in_range;

    always_comb begin
        nbytes   = width_of(host_long, cfg_word);
        base     = (nbytes != NB_W'(1)) ? {cur_addr[ADDR_W-1:1], 1'b0} : cur_addr;
        cnt_zero = (rem_cnt == '0);
        acc_rd   = (state == ST_IDLE) && host_rd;
        acc_wr   = (state == ST_IDLE) && host_wr && !host_rd && !cnt_zero;
        step     = acc_rd || acc_wr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (host_rd) state_d = ST_RDATA;   // read accept
            ST_RDATA: state_d = ST_IDLE;                 // data return
        endcase
    end

    // outputs
    always_comb begin
        host_rvalid = (state == ST_RDATA);
        mem_rd      = acc_rd;
    end

    // width and window of the read in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_nbytes   <= NB_W'(1);
            rd_in_range <= 1'b0;
        end else if (acc_rd) begin
            rd_nbytes   <= nbytes;
            rd_in_range <= in_range;
        end
    end

    rdma_window_chk #(
        .ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES),
        .PKT_BASE(PKT_BASE), .PKT_END(PKT_END)
    ) i_window (
        .addr(base), .nbytes(nbytes), .in_range(in_range)
    );

    rdma_lane_map #(.ADDR_W(ADDR_W)) i_lanes (
        .base(base), .nbytes(nbytes), .in_range(in_range), .wr_go(acc_wr),
        .host_wdata(host_wdata), .rd_nbytes(rd_nbytes), .rd_in_range(rd_in_range),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .host_rdata(host_rdata)
    );

    rdma_ptr_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ptr (
        .clk(clk), .rst_n(rst_n), .step(step), .nbytes(nbytes),
        .reg_wdata(reg_wdata), .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
        .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
        .cmd_remote(cmd_remote), .irq_clr(irq_clr),
        .cur_addr(cur_addr), .rem_cnt(rem_cnt), .rdc_flag(rdc_flag)
    );

    // R6: no lane write while the count is exhausted
    a_r6_zero_count_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (state == ST_IDLE) && (rem_cnt == '0)) |-> (mem_we == '0));

    // R7: multi-byte writes start on an even lane address
    a_r7_even_base: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we[LANES-1:1]) |-> (mem_addr[0] == 1'b0));

    // R9: read data follows the read strobe by one cycle
    a_r9_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && host_rd) |=> host_rvalid);

    // R13: no back-to-back data returns
    a_r13_single_return: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);
endmodule

// File: tb/test_rdma_data_port.sv
`timescale 1ns/1ps
module test_rdma_data_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 0, host_wr = 0, host_long = 0, cfg_word = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [7:0]  ring_start_pg = 8'h04, ring_stop_pg = 8'h06;
    logic [7:0]  reg_wdata = '0;
    logic        ld_addr_lo = 0, ld_addr_hi = 0, ld_cnt_lo = 0, ld_cnt_hi = 0;
    logic        cmd_remote = 0, irq_clr = 0;
    logic        mem_rd;
    logic [3:0]  mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic [15:0] cur_addr, rem_cnt;
    logic        rdc_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rdma_data_port #(
        .ADDR_W(16), .CNT_W(16), .PROM_BYTES(32), .PKT_BASE('h0400), .PKT_END('h0600)
    ) i_rdma_data_port (.*);

    // behavioural synchronous memory, four byte lanes
    logic [7:0] mem [0:2047];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
            mem_rdata <= '0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (mem_we[k]) mem[mem_addr[k*16 +: 11]] <= mem_wdata[8*k +: 8];
                mem_rdata[8*k +: 8] <= mem[mem_addr[k*16 +: 11]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ld(input int which, input logic [7:0] v);
        @(negedge clk);
        reg_wdata = v;
        ld_addr_lo = (which == 0); ld_addr_hi = (which == 1);
        ld_cnt_lo  = (which == 2); ld_cnt_hi  = (which == 3);
        @(negedge clk);
        {ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi} = '0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c);
        ld(0, a[7:0]); ld(1, a[15:8]); ld(2, c[7:0]); ld(3, c[15:8]);
    endtask

    task automatic wr_acc(input logic [31:0] d, output logic [3:0] we_seen);
        @(negedge clk);
        host_wr = 1; host_wdata = d;
        #1 we_seen = mem_we;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd_acc(output logic [31:0] d, output logic v);
        @(negedge clk);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        v = host_rvalid; d = host_rdata;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 addr", cur_addr, 0);
        check("R1 cnt", rem_cnt, 0);
        check("R1 flag", rdc_flag, 0);
        check("R1 rvalid", host_rvalid, 0);
    endtask

    task automatic t_byte_write();
        logic [3:0] we; logic [31:0] d; logic v;
        cfg_word = 0; host_long = 0;
        setup(16'h0410, 16'd3);
        check("R2 addr load", cur_addr, 16'h0410);
        check("R2 cnt load", rem_cnt, 16'd3);
        wr_acc(32'h11, we);
        check("R3 byte lane", we, 4'b0001);
        check("R3 byte step", cur_addr, 16'h0411);
        check("R5 decrement", rem_cnt, 16'd2);
        wr_acc(32'h22, we);
        check("R5 no flag yet", rdc_flag, 0);
        wr_acc(32'h33, we);
        check("R5 zero", rem_cnt, 0);
        check("R5 flag", rdc_flag, 1);
        pulse_clr();
        check("R11 clear", rdc_flag, 0);
        wr_acc(32'h44, we);
        check("R6 no we", we, 4'b0000);
        check("R6 addr held", cur_addr, 16'h0413);
        check("R6 flag held", rdc_flag, 0);
        setup(16'h0410, 16'd4);
        rd_acc(d, v); check("R9 valid", v, 1); check("R9 byte0", d, 32'h11);
        rd_acc(d, v); check("R9 byte1", d, 32'h22);
        rd_acc(d, v); check("R9 byte2", d, 32'h33);
        rd_acc(d, v); check("R6 memory untouched", d, 32'h00);
        check("R5 read done", rdc_flag, 1);
        @(negedge clk);
        check("R9 rvalid drops", host_rvalid, 0);
    endtask

    task automatic t_word();
        logic [3:0] we; logic [31:0] d; logic v;
        pulse_clr();
        cfg_word = 1;
        setup(16'h0420, 16'd4);
        wr_acc(32'hBEEF, we);
        check("R3 word lanes", we, 4'b0011);
        check("R3 word step", cur_addr, 16'h0422);
        wr_acc(32'h1234, we);
        check("R5 word done", rdc_flag, 1);
        cfg_word = 0;
        setup(16'h0420, 16'd4);
        rd_acc(d, v); check("R7 le byte0", d, 32'hEF);
        rd_acc(d, v); check("R7 le byte1", d, 32'hBE);
        rd_acc(d, v); check("R7 le byte2", d, 32'h34);
        rd_acc(d, v); check("R7 le byte3", d, 32'h12);
        cfg_word = 1;
        setup(16'h0421, 16'd2);
        rd_acc(d, v); check("R7 odd aligned", d, 32'hBEEF);
        check("R7 odd step", cur_addr, 16'h0423);
        cfg_word = 0;
    endtask

    task automatic t_long();
        logic [3:0] we; logic [31:0] d; logic v;
        host_long = 1;
        setup(16'h0430, 16'd8);
        wr_acc(32'hCAFEF00D, we);
        check("R3 long lanes", we, 4'b1111);
        check("R3 long step", cur_addr, 16'h0434);
        check("R3 long cnt", rem_cnt, 16'd4);
        setup(16'h0430, 16'd4);
        rd_acc(d, v); check("R3 long read", d, 32'hCAFEF00D);
        setup(16'h001C, 16'd4);
        wr_acc(32'h01020304, we);
        check("R8 prom write", we, 4'b1111);
        setup(16'h001C, 16'd4);
        rd_acc(d, v); check("R8 prom read", d, 32'h01020304);
        setup(16'h001E, 16'd4);
        rd_acc(d, v); check("R8 prom straddle", d, 32'hFFFFFFFF);
        setup(16'h05FE, 16'd4);
        rd_acc(d, v); check("R8 window straddle", d, 32'hFFFFFFFF);
        host_long = 0;
    endtask

    task automatic t_wrap();
        logic [3:0] we;
        cfg_word = 1;
        setup(16'h05FE, 16'd6);
        wr_acc(32'hA1A2, we);
        check("R4 word fold", cur_addr, 16'h0400);
        check("R4 word cnt", rem_cnt, 16'd4);
        cfg_word = 0;
        setup(16'h05FF, 16'd2);
        wr_acc(32'h5A, we);
        check("R4 byte fold", cur_addr, 16'h0400);
    endtask

    task automatic t_short_and_oob();
        logic [3:0] we; logic [31:0] d; logic v;
        pulse_clr();
        cfg_word = 1;
        setup(16'h0440, 16'd1);
        wr_acc(32'h7777, we);
        check("R5 count below width", rem_cnt, 0);
        check("R5 short flag", rdc_flag, 1);
        cfg_word = 0;
        setup(16'h0100, 16'd8);
        rd_acc(d, v); check("R8 oob byte", d, 32'h000000FF);
        cfg_word = 1;
        rd_acc(d, v); check("R8 oob word", d, 32'h0000FFFF);
        host_long = 1;
        rd_acc(d, v); check("R8 oob long", d, 32'hFFFFFFFF);
        check("R8 oob advance", cur_addr, 16'h0107);
        host_long = 0; cfg_word = 0;
        wr_acc(32'h99, we);
        check("R8 oob write dropped", we, 4'b0000);
        check("R8 oob write advance", cur_addr, 16'h0108);
    endtask

    task automatic t_cmd_and_zero_read();
        logic [31:0] d; logic v;
        pulse_clr();
        setup(16'h0410, 16'd0);
        @(negedge clk); cmd_remote = 1; @(negedge clk); cmd_remote = 0;
        check("R10 zero length", rdc_flag, 1);
        pulse_clr();
        setup(16'h0410, 16'd5);
        @(negedge clk); cmd_remote = 1; @(negedge clk); cmd_remote = 0;
        check("R10 nonzero ignored", rdc_flag, 0);
        setup(16'h0410, 16'd0);
        rd_acc(d, v);
        check("R12 data", d, 32'h11);
        check("R12 advance", cur_addr, 16'h0411);
        check("R12 flag", rdc_flag, 1);
        check("R12 cnt", rem_cnt, 0);
    endtask

    task automatic t_held_strobe();
        logic [3:0] we;
        setup(16'h0410, 16'd4);
        @(negedge clk); host_rd = 1; host_wr = 1; host_wdata = 32'hEE;
        #1 we = mem_we;
        check("R13 read wins", we, 4'b0000);
        @(negedge clk); host_wr = 0;
        @(negedge clk); host_rd = 0;
        @(negedge clk);
        check("R13 one access addr", cur_addr, 16'h0411);
        check("R13 one access cnt", rem_cnt, 16'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_byte_write();
        t_word();
        t_long();
        t_wrap();
        t_short_and_oob();
        t_cmd_and_zero_read();
        t_held_strobe();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule